// File: doc/BRIEF.md
# Shared Interrupt CPU-Target Mapper

This block holds the CPU routing for the shared interrupts of an interrupt distributor. Software sees the routing as 32-bit words behind a simple register port. Each word covers four consecutive interrupts, one byte per interrupt. Byte `i` of a word belongs to interrupt `base + i`, and bit `c` of that byte names CPU `c`. The first eight words cover the per-CPU (banked) interrupts. Those words are read-only and report the requesting CPU. The words after them cover the shared interrupts.

The block holds every shared interrupt to a single CPU. On a write it keeps only the lowest set bit of each byte, and an empty byte means CPU 0. It stores the result in two forms: as a CPU index, and as a per-interrupt one-hot bitmap that the pending logic consumes. A read rebuilds the byte masks from the bitmap. A write to a shared word raises an update strobe one cycle later, so that the pending state can be re-evaluated.

Top module: `tgt_mapper`

## Requirements
- R1: After reset every shared interrupt has CPU index 0 and target byte 0x01, so a read of any shared word returns 0x01010101.
- R2: On a write to a shared word, the lowest set bit of byte `i` of the write data selects the target CPU index of interrupt `base + i`.
- R3: A zero byte in the write data sets that interrupt's target to CPU index 0.
- R4: After any write, each shared interrupt's target byte (`tgt_bits_o[8*s +: 8]`) has at most one bit set. That bit is at its stored CPU index, and the bits of all other CPUs are clear.
- R5: A read (`rd_i` high at a clock edge) returns in `rdata_o` from the next cycle a word whose byte `i` is the target byte of interrupt `base + i`. In every other cycle `rdata_o` is zero.
- R6: Writes to word addresses 0 to 7 (the banked range) change neither stored index nor target bits, and raise no update strobe.
- R7: A read of word addresses 0 to 7 returns `1 << req_cpu_i` replicated into all four bytes.
- R8: `update_o` is high for exactly the one cycle after a write to a shared word, and low at all other times.
- R9: A selected CPU index at or above `online_cpus_i` (sampled with the write) is still stored in `tgt_idx_o`, but its target byte is zero.
- R10: A read and a write to the same word in one cycle return the contents from before the write.
- R11: Addresses beyond the last shared word read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address within the target region |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data, four byte masks |
| req_cpu_i | input | 3 | Id of the requesting CPU |
| online_cpus_i | input | 4 | Number of online CPUs (0 to 8) |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| update_o | output | 1 | One-cycle pulse after a shared write |
| tgt_idx_o | output | 3*NUM_SPI | Stored CPU index, interrupt `s` at bits `3*s +: 3` |
| tgt_bits_o | output | 8*NUM_SPI | One-hot target byte, interrupt `s` at bits `8*s +: 8` |

## Verification
A read and a write can reach the same shared word in the same cycle. The read mux must then report the contents from before the edge, while the store and the update strobe take the new value at that edge. The bench issues both strobes together on words whose old and new masks differ, including a byte that selects an offline CPU. It expects the old word in `rdata_o` the next cycle, and at the same time the new indices, new bitmap and a raised `update_o`. It also repeats the read on its own afterwards to confirm the new value.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  localparam int LANE_W = 8;   // one CPU bit per lane bit
  localparam int LANES  = 4;   // interrupts per 32-bit word
  localparam int IDX_W  = 3;   // CPU index width
  localparam int CNT_W  = 4;   // online CPU count width

  // Lowest set bit of a byte mask; zero mask selects CPU 0.
  function automatic logic [IDX_W-1:0] lowest_cpu(input logic [LANE_W-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LANE_W - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // One-hot target byte for a CPU index, empty if the CPU is offline.
  function automatic logic [LANE_W-1:0] cpu_mask(input logic [IDX_W-1:0] idx,
                                                 input logic [CNT_W-1:0] online);
    if ({1'b0, idx} < online) return LANE_W'(1) << idx;
    return '0;
  endfunction

  // Banked-range read value for a requester.
  function automatic logic [31:0] banked_word(input logic [IDX_W-1:0] req);
    logic [LANE_W-1:0] b;
    b = LANE_W'(1) << req;
    return {LANES{b}};
  endfunction
endpackage

// File: rtl/tgt_lane_reduce.sv
module tgt_lane_reduce
  import tgt_pkg::*;
(
  input  logic [31:0]              wdata_i,
  input  logic [CNT_W-1:0]         online_i,
  output logic [LANES*IDX_W-1:0]   idx_o,
  output logic [LANES*LANE_W-1:0]  mask_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0] sel;
    assign sel                       = lowest_cpu(wdata_i[l*LANE_W +: LANE_W]);
    assign idx_o[l*IDX_W +: IDX_W]   = sel;
    assign mask_o[l*LANE_W +: LANE_W] = cpu_mask(sel, online_i);
  end
endmodule

// File: rtl/tgt_store.sv
module tgt_store
  import tgt_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int SW_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [SW_W-1:0]             widx_i,
  input  logic [LANES*IDX_W-1:0]      new_idx_i,
  input  logic [LANES*LANE_W-1:0]     new_mask_i,
  output logic [NUM_SPI*IDX_W-1:0]    idx_q_o,
  output logic [NUM_SPI*LANE_W-1:0]   bits_q_o
);
  for (genvar s = 0; s < NUM_SPI; s++) begin : g_irq
    localparam int W = s / LANES;
    localparam int L = s % LANES;
    logic hit;
    assign hit = we_i && (widx_i == SW_W'(W));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q_o[s*IDX_W +: IDX_W]    <= '0;
        bits_q_o[s*LANE_W +: LANE_W] <= LANE_W'(1);
      end else if (hit) begin
        idx_q_o[s*IDX_W +: IDX_W]    <= new_idx_i[L*IDX_W +: IDX_W];
        bits_q_o[s*LANE_W +: LANE_W] <= new_mask_i[L*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/tgt_read_mux.sv
module tgt_read_mux
  import tgt_pkg::*;
#(
  parameter int NUM_SPI    = 32,
  parameter int PRIV_WORDS = 8,
  parameter int ADDR_W     = 6
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [IDX_W-1:0]           req_i,
  input  logic [NUM_SPI*LANE_W-1:0]  bits_i,
  output logic [31:0]                word_o
);
  localparam int SH_WORDS = NUM_SPI / LANES;

  always_comb begin
    int sh;
    sh     = int'(addr_i) - PRIV_WORDS;
    word_o = '0;
    if (int'(addr_i) < PRIV_WORDS)             word_o = banked_word(req_i);
    else if (sh < SH_WORDS)                    word_o = bits_i[sh*32 +: 32];
  end
endmodule

// File: rtl/tgt_mapper.sv
module tgt_mapper
  import tgt_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int PRIV_IRQ = 32,
  parameter int ADDR_W   = 6,
  localparam int NUM_SPI = NUM_IRQ - PRIV_IRQ
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [31:0]                wdata_i,
  input  logic [2:0]                 req_cpu_i,
  input  logic [3:0]                 online_cpus_i,
  output logic [31:0]                rdata_o,
  output logic                       update_o,
  output logic [NUM_SPI*3-1:0]       tgt_idx_o,
  output logic [NUM_SPI*8-1:0]       tgt_bits_o
);
  localparam int PRIV_WORDS = PRIV_IRQ / LANES;
  localparam int SH_WORDS   = NUM_SPI / LANES;
  localparam int SW_W       = (SH_WORDS > 1) ? $clog2(SH_WORDS) : 1;

  // Named decode events, also observed by the checker.
  logic              is_priv, is_shared, wr_shared, wr_priv;
  logic [SW_W-1:0]   widx;
  logic [LANES*IDX_W-1:0]  new_idx;
  logic [LANES*LANE_W-1:0] new_mask;
  logic [31:0]       rd_word;

  assign is_priv   = int'(addr_i) < PRIV_WORDS;
  assign is_shared = !is_priv && (int'(addr_i) < PRIV_WORDS + SH_WORDS);
  assign wr_shared = wr_i && is_shared;
  assign wr_priv   = wr_i && is_priv;
  assign widx      = SW_W'(int'(addr_i) - PRIV_WORDS);

  tgt_lane_reduce u_reduce (
    .wdata_i  (wdata_i),
    .online_i (online_cpus_i),
    .idx_o    (new_idx),
    .mask_o   (new_mask)
  );

  tgt_store #(.NUM_SPI(NUM_SPI), .SW_W(SW_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (wr_shared),
    .widx_i     (widx),
    .new_idx_i  (new_idx),
    .new_mask_i (new_mask),
    .idx_q_o    (tgt_idx_o),
    .bits_q_o   (tgt_bits_o)
  );

  tgt_read_mux #(.NUM_SPI(NUM_SPI), .PRIV_WORDS(PRIV_WORDS), .ADDR_W(ADDR_W)) u_rmux (
    .addr_i (addr_i),
    .req_i  (req_cpu_i),
    .bits_i (tgt_bits_o),
    .word_o (rd_word)
  );

  // Read data sampled from pre-write state; update strobe follows shared writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      update_o <= 1'b0;
    end else begin
      rdata_o  <= rd_i ? rd_word : '0;
      update_o <= wr_shared;
    end
  end
endmodule

// File: rtl/tgt_mapper_chk.sv
module tgt_mapper_chk
  import tgt_pkg::*;
#(
  parameter int NUM_SPI = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_i,
  input logic [2:0]            req_cpu_i,
  input logic                  is_priv,
  input logic                  wr_shared,
  input logic                  wr_priv,
  input logic                  update_o,
  input logic [31:0]           rdata_o,
  input logic [NUM_SPI*3-1:0]  tgt_idx_o,
  input logic [NUM_SPI*8-1:0]  tgt_bits_o
);
  AST_UPD_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_shared |=> update_o); // R8
  AST_UPD_ONLY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_shared |=> !update_o); // R8
  AST_BANKED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_priv |=> ($stable(tgt_bits_o) && $stable(tgt_idx_o))); // R6
  AST_BANKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && is_priv) |=> (rdata_o == banked_word($past(req_cpu_i)))); // R7
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (rdata_o == '0)); // R5

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_irq
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tgt_bits_o[s*8 +: 8]) <= 1); // R4
    AST_BIT_AT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_bits_o[s*8 +: 8] != '0) |-> (tgt_bits_o[s*8 +: 8] == (8'(1) << tgt_idx_o[s*3 +: 3]))); // R4
  end
endmodule

bind tgt_mapper tgt_mapper_chk #(.NUM_SPI(NUM_SPI)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_i       (rd_i),
  .req_cpu_i  (req_cpu_i),
  .is_priv    (is_priv),
  .wr_shared  (wr_shared),
  .wr_priv    (wr_priv),
  .update_o   (update_o),
  .rdata_o    (rdata_o),
  .tgt_idx_o  (tgt_idx_o),
  .tgt_bits_o (tgt_bits_o)
);

// File: tb/tgt_mapper_bench.sv
`timescale 1ns/1ps
module tgt_mapper_bench;
  localparam int NSPI = 32;
  localparam int PRIVW = 8;
  localparam int SHW = NSPI / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [2:0] req = '0;
  logic [3:0] online = 4'd4;
  logic [31:0] rdata;
  logic upd;
  logic [NSPI*3-1:0] tidx;
  logic [NSPI*8-1:0] tbits;

  always #10 clk = ~clk;

  tgt_mapper u_tgt_mapper (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .req_cpu_i(req), .online_cpus_i(online),
    .rdata_o(rdata), .update_o(upd), .tgt_idx_o(tidx), .tgt_bits_o(tbits)
  );

  int n_run = 0, n_fail = 0;
  int m_idx [NSPI];
  logic [7:0] m_bits [NSPI];

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input int a, input int r);
    logic [31:0] w;
    logic [7:0] one;
    one = 8'h01 << r;
    if (a < PRIVW) return {one, one, one, one};
    if (a >= PRIVW + SHW) return '0;
    for (int l = 0; l < 4; l++) w[l*8 +: 8] = m_bits[(a - PRIVW)*4 + l];
    return w;
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    if (a < PRIVW || a >= PRIVW + SHW) return;
    for (int l = 0; l < 4; l++) begin
      int sel;
      sel = 0;
      for (int b = 7; b >= 0; b--) if (d[l*8 + b]) sel = b;
      m_idx[(a - PRIVW)*4 + l]  = sel;
      m_bits[(a - PRIVW)*4 + l] = (sel < int'(online)) ? (8'h01 << sel) : 8'h00;
    end
  endtask

  task automatic check_map(input string tag);
    bit ok;
    int bad;
    ok = 1; bad = 0;
    for (int s = 0; s < NSPI; s++) begin
      if (int'(tidx[s*3 +: 3]) != m_idx[s] || tbits[s*8 +: 8] != m_bits[s]) begin
        if (ok) bad = s;
        ok = 0;
      end
    end
    check(ok, tag, {tidx[bad*3 +: 3], 5'd0, tbits[bad*8 +: 8], 16'(bad)},
          {3'(m_idx[bad]), 5'd0, m_bits[bad], 16'(bad)});
  endtask

  // Driver: one access per call, pushes expected read data first.
  task automatic op(input bit r, input bit w, input int a, input logic [31:0] d,
                    input int rq, input string tag);
    bit sh;
    sh = (a >= PRIVW) && (a < PRIVW + SHW);
    if (r) sb.push_back('{model_word(a, rq), tag});
    if (w) model_write(a, d);
    @(negedge clk);
    check(upd == 1'b0, "R8 idle strobe", 32'(upd), 32'd0);
    rd = r; wr = w; addr = 6'(a); wdata = d; req = 3'(rq);
    @(negedge clk);
    rd = 0; wr = 0;
    check(upd == (w && sh), {"R8 strobe after ", tag}, 32'(upd), 32'(w && sh));
    check_map({"R4 map after ", tag});
  endtask

  // Monitor: compare read data the cycle after a sampled read strobe.
  initial begin
    forever begin
      bit took;
      @(posedge clk);
      took = rd;
      #2;
      if (took) begin
        if (sb.size() == 0) check(0, "R5 unexpected read", rdata, 32'd0);
        else begin
          rd_item_t it;
          it = sb.pop_front();
          check(rdata == it.exp, it.tag, rdata, it.exp);
        end
      end else if (rst_n) begin
        check(rdata == 32'd0, "R5 idle rdata", rdata, 32'd0);
      end
    end
  end

  initial begin
    #(200000 * 20);
    check(0, "watchdog", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int s = 0; s < NSPI; s++) begin m_idx[s] = 0; m_bits[s] = 8'h01; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_map("R1 reset map");
    op(1, 0, 8, 0, 0, "R1 reset read word 8");
    op(1, 0, 15, 0, 3, "R1 reset read word 15");
    // R2 R3 R9: lowest bit, empty byte, offline CPU 7 with 4 online
    op(0, 1, 8, 32'h800C0006, 0, "R2 R3 R9 write");
    op(1, 0, 8, 0, 0, "R5 R9 readback word 8");
    op(0, 1, 15, 32'hFFFFFFFF, 0, "R2 all-ones write");
    op(1, 0, 15, 0, 1, "R5 readback word 15");
    op(0, 1, 9, 32'h08040201, 0, "R2 one-hot write");
    op(1, 0, 9, 0, 0, "R5 readback word 9");
    // R6 R7: banked range
    op(0, 1, 3, 32'h80808080, 0, "R6 banked write ignored");
    op(1, 0, 3, 0, 2, "R7 banked read req 2");
    op(1, 0, 0, 0, 7, "R7 banked read req 7");
    op(1, 1, 7, 32'h0, 5, "R6 R7 banked rw");
    // R11: beyond last shared word
    op(0, 1, 20, 32'h02020202, 0, "R11 out-of-range write");
    op(1, 0, 20, 0, 1, "R11 out-of-range read");
    op(1, 0, 16, 0, 1, "R11 first word past end");
    // R10: same-cycle read and write
    op(1, 1, 9, 32'h40100880, 0, "R10 rw returns old word 9");
    op(1, 0, 9, 0, 0, "R10 R9 new word 9");
    // R9: more CPUs online, high CPU now receives its bit
    online = 4'd8;
    op(0, 1, 10, 32'h80C0E0F0, 0, "R9 eight online write");
    op(1, 0, 10, 0, 0, "R9 R2 readback word 10");
    online = 4'd0;
    op(0, 1, 11, 32'h00000001, 0, "R9 none online write");
    op(1, 0, 11, 0, 0, "R9 none online readback");
    online = 4'd5;
    // R5: pseudo-random sweep over shared words
    lf = 32'h1D872B41;
    for (int k = 0; k < 24; k++) begin
      int a;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      a = PRIVW + int'(lf[2:0]);
      op(lf[3], 1, a, lf, 0, "R5 R10 sweep rw");
      op(1, 0, a, 0, int'(lf[6:4]), "R5 sweep readback");
    end
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R5 all reads returned", 32'(sb.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule